// File: doc/BRIEF.md
# GPIO Pad Configuration Register File

This block holds the pad configuration for one port of eight pins. A simple word-addressed register bus sets each pin's electrical and functional setup. The bus has a write strobe, an address, write data and combinational read data. For every pin the block stores:

- direction
- digital enable
- analog select
- pull-up and pull-down
- open-drain
- a one-of-three drive strength with slew control
- an alternate-function enable and a 4-bit function selector

The per-pin results leave the block as flat vectors that feed the pad models.

Some bits are tied together in hardware, so software never has to clear them in a second step. Setting a pull in one direction removes the opposite pull on the same pin. Picking one drive strength for a pin removes the other two.

Some pins come out of reset in their alternate function. A commit mask guards these pins. While a pin's commit bit is 0, the fields that could take it away from that function are frozen. The commit mask can only be written after a 32-bit key has been written to the lock register.

Top module: `gpio_pad_cfg`

## Requirements
- R1: After reset every pin is set up as follows:
  - direction is input, digital enable is 1, and pull-up, pull-down, open-drain and slew are all 0;
  - drive is 2 mA, and the effective analog output is 0;
  - special pins (parameter `SPECIAL_MASK`, default 8'h03) have alternate-function enable 1, and the selector resets to `SPECIAL_FSEL` (default 32'h0000_0011);
  - the commit mask resets to the inverse of `SPECIAL_MASK`, and the lock register reads 1.
- R2: Each of the plain registers at word offsets 0 (direction), 2 (analog select), 5 (open-drain) and 11 (function selector) accepts a full write and reads back what was written. Narrow registers read back zero-extended. Pin i's function field is bits [4i+3:4i] of register 11 and appears at the same bits of `fsel_o`.
- R3: Writes to pull-up (offset 3) replace the committed bits of pull-up and clear pull-down (offset 4) wherever a 1 is written. Writes to pull-down behave the same way with the roles swapped. No pin ever has both pulls set.
- R4: Writing to a drive register (offset 6 = 2 mA, 7 = 4 mA, 8 = 8 mA) sets that strength for every pin written 1 and clears the same bits in the other two registers. Bits written 0 leave the pin unchanged. Each pin has exactly one strength. `drv_sel_o[2i+1:2i]` encodes pin i as 0 for 2 mA, 1 for 4 mA and 2 for 8 mA.
- R5: The slew register (offset 9) reaches `slew_o` only for pins set to 8 mA drive.
- R6: `ana_o` for a pin is 1 only when its analog select bit is 1 and its digital enable is 0.
- R7: Writing 32'h4C4F434B to the lock register (offset 12) unlocks the bank, and the register then reads 0. Writing any other value locks the bank, and it then reads 1.
- R8: Writes to the commit register (offset 13) take effect only while the bank is unlocked. While the bank is locked they are ignored.
- R9: For pins whose commit bit is 0, writes to digital enable (offset 1), alternate-function enable (offset 10), pull-up and pull-down leave those bits unchanged.
- R10: Reads at unmapped offsets 14 and 15 return 0, and writes there change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe |
| addr_i | input | 4 | Word address of register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of addressed register |
| dir_o | output | 8 | Per-pin output enable |
| dig_en_o | output | 8 | Per-pin digital enable |
| ana_o | output | 8 | Per-pin effective analog mode |
| pu_o | output | 8 | Per-pin pull-up |
| pd_o | output | 8 | Per-pin pull-down |
| od_o | output | 8 | Per-pin open-drain |
| drv_sel_o | output | 16 | Per-pin 2-bit drive strength code |
| slew_o | output | 8 | Per-pin effective slew control |
| afen_o | output | 8 | Per-pin alternate-function enable |
| fsel_o | output | 32 | Per-pin 4-bit function selector |

## Verification
Pull writes are tried with three kinds of mask:
- masks that cover protected pins, which tells commit gating apart from a plain store;
- masks that overlap bits already set in the opposite pull, which shows the clear-on-write;
- masks that touch only bits that are not set in the opposite pull.

Drive writes are tried both with set bits and with an all-zero mask. The zero mask tells "write 1 moves the pin" apart from "write replaces the register".

Key writes use both the exact key and a near value. Commit and digital-enable writes are repeated before and after unlocking, so a gate that is stuck open or stuck closed shows up.

// File: rtl/gpio_cfg_pkg.sv
package gpio_cfg_pkg;
  localparam int unsigned REG_AW = 4;
  localparam int unsigned BUS_DW = 32;
  localparam logic [BUS_DW-1:0] UNLOCK_KEY = 32'h4C4F434B;

  typedef enum logic [REG_AW-1:0] {
    RA_DIR    = 4'd0,
    RA_DEN    = 4'd1,
    RA_ANA    = 4'd2,
    RA_PU     = 4'd3,
    RA_PD     = 4'd4,
    RA_OD     = 4'd5,
    RA_DRV2   = 4'd6,
    RA_DRV4   = 4'd7,
    RA_DRV8   = 4'd8,
    RA_SLEW   = 4'd9,
    RA_AFEN   = 4'd10,
    RA_FSEL   = 4'd11,
    RA_LOCK   = 4'd12,
    RA_COMMIT = 4'd13
  } reg_addr_e;
endpackage

// File: rtl/gpio_lock_ctrl.sv
module gpio_lock_ctrl
  import gpio_cfg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter logic [NUM_PINS-1:0] SPECIAL_MASK = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_lock_i,
  input  logic                wr_commit_i,
  input  logic [BUS_DW-1:0]   wdata_i,
  output logic                locked_o,
  output logic [NUM_PINS-1:0] commit_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      locked_o <= 1'b1;
      commit_o <= ~SPECIAL_MASK;
    end else begin
      if (wr_lock_i) locked_o <= (wdata_i != UNLOCK_KEY);
      if (wr_commit_i && !locked_o) commit_o <= wdata_i[NUM_PINS-1:0];
    end
  end

  a_r7_relock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lock_i && wdata_i != UNLOCK_KEY) |=> locked_o);
  a_r7_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_lock_i && wdata_i == UNLOCK_KEY) |=> !locked_o);
  a_r8_commit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(wr_commit_i && !locked_o)) |=> $stable(commit_o));
endmodule

// File: rtl/gpio_pull_pair.sv
module gpio_pull_pair #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_pu_i,
  input  logic                wr_pd_i,
  input  logic [NUM_PINS-1:0] wdata_i,
  input  logic [NUM_PINS-1:0] commit_i,
  output logic [NUM_PINS-1:0] pu_o,
  output logic [NUM_PINS-1:0] pd_o
);
  logic [NUM_PINS-1:0] hit;
  assign hit = wdata_i & commit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pu_o <= '0;
      pd_o <= '0;
    end else if (wr_pu_i) begin
      pu_o <= (pu_o & ~commit_i) | hit;
      pd_o <= pd_o & ~hit;
    end else if (wr_pd_i) begin
      pd_o <= (pd_o & ~commit_i) | hit;
      pu_o <= pu_o & ~hit;
    end
  end

  a_r3_pull_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pu_o & pd_o) == '0);
  a_r9_pu_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pu_i |=> ((pu_o ^ $past(pu_o)) & ~$past(commit_i)) == '0);
  a_r9_pd_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pd_i |=> ((pd_o ^ $past(pd_o)) & ~$past(commit_i)) == '0);
endmodule

// File: rtl/gpio_drive_sel.sv
module gpio_drive_sel #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_d2_i,
  input  logic                  wr_d4_i,
  input  logic                  wr_d8_i,
  input  logic                  wr_slew_i,
  input  logic [NUM_PINS-1:0]   wdata_i,
  output logic [NUM_PINS-1:0]   d2_o,
  output logic [NUM_PINS-1:0]   d4_o,
  output logic [NUM_PINS-1:0]   d8_o,
  output logic [NUM_PINS-1:0]   slew_raw_o,
  output logic [2*NUM_PINS-1:0] drv_sel_o,
  output logic [NUM_PINS-1:0]   slew_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d2_o       <= '1;
      d4_o       <= '0;
      d8_o       <= '0;
      slew_raw_o <= '0;
    end else begin
      if (wr_d2_i) begin
        d2_o <= d2_o | wdata_i;
        d4_o <= d4_o & ~wdata_i;
        d8_o <= d8_o & ~wdata_i;
      end else if (wr_d4_i) begin
        d4_o <= d4_o | wdata_i;
        d2_o <= d2_o & ~wdata_i;
        d8_o <= d8_o & ~wdata_i;
      end else if (wr_d8_i) begin
        d8_o <= d8_o | wdata_i;
        d2_o <= d2_o & ~wdata_i;
        d4_o <= d4_o & ~wdata_i;
      end
      if (wr_slew_i) slew_raw_o <= wdata_i;
    end
  end

  assign slew_o = slew_raw_o & d8_o;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    assign drv_sel_o[2*i +: 2] = d8_o[i] ? 2'd2 : (d4_o[i] ? 2'd1 : 2'd0);

    a_r4_drive_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot({d8_o[i], d4_o[i], d2_o[i]}));
  end
endmodule

// File: rtl/gpio_pad_cfg.sv
module gpio_pad_cfg
  import gpio_cfg_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter logic [NUM_PINS-1:0]   SPECIAL_MASK = 8'h03,
  parameter logic [4*NUM_PINS-1:0] SPECIAL_FSEL = 32'h0000_0011
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_AW-1:0]     addr_i,
  input  logic [BUS_DW-1:0]     wdata_i,
  output logic [BUS_DW-1:0]     rdata_o,
  output logic [NUM_PINS-1:0]   dir_o,
  output logic [NUM_PINS-1:0]   dig_en_o,
  output logic [NUM_PINS-1:0]   ana_o,
  output logic [NUM_PINS-1:0]   pu_o,
  output logic [NUM_PINS-1:0]   pd_o,
  output logic [NUM_PINS-1:0]   od_o,
  output logic [2*NUM_PINS-1:0] drv_sel_o,
  output logic [NUM_PINS-1:0]   slew_o,
  output logic [NUM_PINS-1:0]   afen_o,
  output logic [4*NUM_PINS-1:0] fsel_o
);
  localparam int unsigned FSEL_W = 4 * NUM_PINS;
  localparam int unsigned PAD_W  = BUS_DW - NUM_PINS;

  function automatic logic [BUS_DW-1:0] zext(input logic [NUM_PINS-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  logic [NUM_PINS-1:0] ana_q, commit, d2, d4, d8, slew_raw, wd;
  logic                locked;

  assign wd = wdata_i[NUM_PINS-1:0];

  function automatic logic hit(input logic we, input logic [REG_AW-1:0] a,
                               input reg_addr_e r);
    return we && (a == r);
  endfunction

  gpio_lock_ctrl #(.NUM_PINS(NUM_PINS), .SPECIAL_MASK(SPECIAL_MASK)) u_lock (
    .clk_i, .rst_ni,
    .wr_lock_i   (hit(we_i, addr_i, RA_LOCK)),
    .wr_commit_i (hit(we_i, addr_i, RA_COMMIT)),
    .wdata_i,
    .locked_o    (locked),
    .commit_o    (commit)
  );

  gpio_pull_pair #(.NUM_PINS(NUM_PINS)) u_pull (
    .clk_i, .rst_ni,
    .wr_pu_i  (hit(we_i, addr_i, RA_PU)),
    .wr_pd_i  (hit(we_i, addr_i, RA_PD)),
    .wdata_i  (wd),
    .commit_i (commit),
    .pu_o, .pd_o
  );

  gpio_drive_sel #(.NUM_PINS(NUM_PINS)) u_drv (
    .clk_i, .rst_ni,
    .wr_d2_i    (hit(we_i, addr_i, RA_DRV2)),
    .wr_d4_i    (hit(we_i, addr_i, RA_DRV4)),
    .wr_d8_i    (hit(we_i, addr_i, RA_DRV8)),
    .wr_slew_i  (hit(we_i, addr_i, RA_SLEW)),
    .wdata_i    (wd),
    .d2_o       (d2),
    .d4_o       (d4),
    .d8_o       (d8),
    .slew_raw_o (slew_raw),
    .drv_sel_o,
    .slew_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o    <= '0;
      dig_en_o <= '1;
      ana_q    <= '0;
      od_o     <= '0;
      afen_o   <= SPECIAL_MASK;
      fsel_o   <= SPECIAL_FSEL;
    end else if (we_i) begin
      unique case (addr_i)
        RA_DIR:  dir_o    <= wd;
        RA_DEN:  dig_en_o <= (dig_en_o & ~commit) | (wd & commit);
        RA_ANA:  ana_q    <= wd;
        RA_OD:   od_o     <= wd;
        RA_AFEN: afen_o   <= (afen_o & ~commit) | (wd & commit);
        RA_FSEL: fsel_o   <= wdata_i[FSEL_W-1:0];
        default: ;
      endcase
    end
  end

  assign ana_o = ana_q & ~dig_en_o;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      RA_DIR:    rdata_o = zext(dir_o);
      RA_DEN:    rdata_o = zext(dig_en_o);
      RA_ANA:    rdata_o = zext(ana_q);
      RA_PU:     rdata_o = zext(pu_o);
      RA_PD:     rdata_o = zext(pd_o);
      RA_OD:     rdata_o = zext(od_o);
      RA_DRV2:   rdata_o = zext(d2);
      RA_DRV4:   rdata_o = zext(d4);
      RA_DRV8:   rdata_o = zext(d8);
      RA_SLEW:   rdata_o = zext(slew_raw);
      RA_AFEN:   rdata_o = zext(afen_o);
      RA_FSEL:   rdata_o = {{(BUS_DW-FSEL_W){1'b0}}, fsel_o};
      RA_LOCK:   rdata_o = {{(BUS_DW-1){1'b0}}, locked};
      RA_COMMIT: rdata_o = zext(commit);
      default:   rdata_o = '0;
    endcase
  end

  a_r9_den_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((dig_en_o ^ $past(dig_en_o)) & ~$past(commit)) == '0);
  a_r9_afen_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((afen_o ^ $past(afen_o)) & ~$past(commit)) == '0);
  a_r5_slew_needs_8ma: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slew_o & ~d8) == '0);
  a_r2_fsel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == RA_FSEL) |=> $stable(fsel_o));
endmodule

// File: tb/tb_gpio_pad_cfg.sv
`timescale 1ns/1ps
module tb_gpio_pad_cfg;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [7:0]  dir_o, dig_en_o, ana_o, pu_o, pd_o, od_o, slew_o, afen_o;
  logic [15:0] drv_sel_o;
  logic [31:0] fsel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  gpio_pad_cfg dut (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i, .rdata_o,
    .dir_o, .dig_en_o, .ana_o, .pu_o, .pd_o, .od_o,
    .drv_sel_o, .slew_o, .afen_o, .fsel_o
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  // {write addr, write data, read addr, expected read}
  localparam int NV = 13;
  localparam logic [71:0] VEC [NV] = '{
    {4'd0,  32'h0000_00A5, 4'd0,  32'h0000_00A5}, // R2 dir
    {4'd5,  32'h0000_003C, 4'd5,  32'h0000_003C}, // R2 open-drain
    {4'd11, 32'h7654_3210, 4'd11, 32'h7654_3210}, // R2 fsel
    {4'd3,  32'h0000_00FF, 4'd3,  32'h0000_00FC}, // R9 pull-up gated
    {4'd4,  32'h0000_0030, 4'd3,  32'h0000_00CC}, // R3 pd clears pu
    {4'd3,  32'h0000_0010, 4'd4,  32'h0000_0020}, // R3 pu clears pd
    {4'd8,  32'h0000_000F, 4'd6,  32'h0000_00F0}, // R4 8mA clears 2mA
    {4'd7,  32'h0000_0003, 4'd8,  32'h0000_000C}, // R4 4mA clears 8mA
    {4'd6,  32'h0000_0000, 4'd7,  32'h0000_0003}, // R4 zero no effect
    {4'd1,  32'h0000_0000, 4'd1,  32'h0000_0003}, // R9 den gated
    {4'd10, 32'h0000_0000, 4'd10, 32'h0000_0003}, // R9 afen gated
    {4'd13, 32'h0000_00FF, 4'd13, 32'h0000_00FC}, // R8 commit locked
    {4'd14, 32'hFFFF_FFFF, 4'd15, 32'h0000_0000}  // R10 unmapped
  };

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 dir", {24'h0, dir_o}, 32'h0);
    chk("R1 dig_en", {24'h0, dig_en_o}, 32'hFF);
    chk("R1 pulls", {16'h0, pu_o, pd_o}, 32'h0);
    chk("R1 drive", {16'h0, drv_sel_o}, 32'h0);
    chk("R1 od/slew/ana", {8'h0, od_o, slew_o, ana_o}, 32'h0);
    chk("R1 afen", {24'h0, afen_o}, 32'h03);
    chk("R1 fsel", fsel_o, 32'h0000_0011);
    rd(4'd12, r); chk("R1 lock", r, 32'h1);
    rd(4'd13, r); chk("R1 commit", r, 32'hFC);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:68], VEC[i][67:36]);
      rd(VEC[i][35:32], r);
      chk($sformatf("vec%0d", i), r, VEC[i][31:0]);
    end
    chk("R10 dir untouched", {24'h0, dir_o}, 32'hA5);
    chk("R2 fsel_o", fsel_o, 32'h7654_3210);
    chk("R3 pu_o", {24'h0, pu_o}, 32'h10);
    chk("R4 drv_sel_o", {16'h0, drv_sel_o}, 32'h00A5);

    wr(4'd9, 32'hFF);
    chk("R5 slew_o", {24'h0, slew_o}, 32'h0C);
    wr(4'd2, 32'hFF);
    chk("R6 ana_o", {24'h0, ana_o}, 32'hFC);

    wr(4'd12, 32'h4C4F434A);
    rd(4'd12, r); chk("R7 near key", r, 32'h1);
    wr(4'd12, 32'h4C4F434B);
    rd(4'd12, r); chk("R7 unlocked", r, 32'h0);
    wr(4'd13, 32'hFF);
    rd(4'd13, r); chk("R8 commit unlocked", r, 32'hFF);
    wr(4'd1, 32'h00);
    chk("R9 den after commit", {24'h0, dig_en_o}, 32'h00);
    chk("R6 ana all", {24'h0, ana_o}, 32'hFF);
    wr(4'd12, 32'h0000_1234);
    rd(4'd12, r); chk("R7 relocked", r, 32'h1);
    wr(4'd13, 32'h00);
    rd(4'd13, r); chk("R8 commit relocked", r, 32'hFF);

    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #100us;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule